// File: doc/BRIEF.md
# Latched Position Byte Readout

This block puts two 32-bit position counters, one per axis, onto a single 8-bit read port. Each axis has a snapshot register that copies its counter on every rising clock edge. While a host reads that axis byte by byte, the copying is suspended. All bytes of one read therefore come from the same counter value, even though the counter keeps moving underneath. The counters and the logic that drives them sit outside this block and arrive as plain 32-bit inputs.

A read works as follows. The host pulls the active-low output enable low, picks an axis, and steps through the bytes with a two-bit byte select whose code order is not sequential. It must read the least significant byte last, then raise the enable. That sequence releases the freeze. A host may read 1, 2, 3 or 4 bytes, provided the last byte it reads is the least significant one. The enable and the selects are sampled on the falling clock edge. A tri-state bus is modelled as a data output plus a drive-enable output.

Top module: `pos_byte_readout`

## Requirements
- R1: Each axis has its own asynchronous active-low reset. While it is low, that axis's snapshot reads as zero and its freeze is cleared. The other axis is unaffected.
- R2: While an axis is not frozen, its snapshot takes that axis's counter input at every rising edge. A read shows the counter value that was present at the most recent rising edge.
- R3: A falling edge that samples the output enable low, with an axis selected, freezes that axis. Its snapshot is not loaded at any later rising edge until the freeze is released.
- R4: The freeze is released only by a falling edge that samples the enable high, after an earlier sampled read of the least significant byte of that axis. Raising the enable without that read keeps the snapshot frozen.
- R5: Byte select codes, written as {byte_sel_i[1], byte_sel_i[0]}, are as follows: 2'b01 gives bits 31:24, 2'b11 gives bits 23:16, 2'b00 gives bits 15:8, and 2'b10 gives bits 7:0.
- R6: axis_sel_i = 0 reads the X axis snapshot. axis_sel_i = 1 reads the Y axis snapshot.
- R7: data_en_o equals the inverse of oe_ni. data_o is zero whenever data_en_o is low.
- R8: Reading one axis never freezes the other axis, which keeps tracking its counter.
- R9: A read of the least significant byte alone is a complete read. Raising the enable afterwards releases the freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_x_ni | input | 1 | Asynchronous active-low reset, X axis |
| rst_y_ni | input | 1 | Asynchronous active-low reset, Y axis |
| cnt_x_i | input | 32 | X axis counter value |
| cnt_y_i | input | 32 | Y axis counter value |
| oe_ni | input | 1 | Active-low output enable, also starts a read |
| byte_sel_i | input | 2 | Byte select code (see R5) |
| axis_sel_i | input | 1 | Axis select: 0 = X, 1 = Y |
| data_o | output | 8 | Selected byte, zero when not driven |
| data_en_o | output | 1 | High when data_o would drive the bus |

## Verification
data_o and data_en_o are combinational from the selects and the enable. They are due within the same cycle, so the bench samples them 2 ns after it changes the inputs. A freeze decision is taken on the falling edge in the middle of the cycle in which the enable goes low. It first affects the snapshot at the next rising edge, and the counter value seen then becomes visible one cycle after it was applied. The bench's reference model follows the same edge order. It samples the outputs, then updates the freeze state as of the falling edge, then loads the snapshot as of the rising edge. Each expected byte therefore belongs to exactly the cycle in which it is checked.

// File: rtl/pos_rd_pkg.sv
package pos_rd_pkg;
  localparam int unsigned N_BYTES = 4;
  localparam int unsigned IDX_W   = $clog2(N_BYTES);

  // select code of the byte that ends a read
  localparam logic [1:0] SEL_LSB = 2'b10;

  // non-sequential code to byte index: 01->3, 11->2, 00->1, 10->0
  function automatic logic [IDX_W-1:0] byte_idx(input logic [1:0] sel);
    return {sel[0], ~sel[1]};
  endfunction
endpackage

// File: rtl/pos_inhibit.sv
module pos_inhibit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic lsb_i,
  input  logic oe_ni,
  output logic inh_o
);
  logic inh_q, lsb_q;

  // sampled on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inh_q <= 1'b0;
      lsb_q <= 1'b0;
    end else if (rd_i) begin
      inh_q <= 1'b1;
      if (lsb_i) lsb_q <= 1'b1;
    end else if (oe_ni && inh_q && lsb_q) begin
      inh_q <= 1'b0;
      lsb_q <= 1'b0;
    end
  end

  assign inh_o = inh_q;

  p_set_on_read_r3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    rd_i |=> inh_q);
  p_hold_until_lsb_r4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (inh_q && !lsb_q && !(rd_i && lsb_i)) |=> inh_q);
  p_release_r9: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (inh_q && lsb_q && oe_ni) |=> !inh_q);
endmodule

// File: rtl/pos_latch.sv
module pos_latch #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inh_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] lat_o
);
  logic [CNT_W-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lat_q <= '0;
    else if (!inh_i) lat_q <= cnt_i;
  end

  assign lat_o = lat_q;

  p_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inh_i |=> $stable(lat_q));
  p_tracks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inh_i |=> lat_q == $past(cnt_i));
endmodule

// File: rtl/pos_byte_mux.sv
module pos_byte_mux
  import pos_rd_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = N_BYTES * BYTE_W
) (
  input  logic [CNT_W-1:0]  lat_x_i,
  input  logic [CNT_W-1:0]  lat_y_i,
  input  logic              axis_i,
  input  logic [1:0]        sel_i,
  input  logic              en_i,
  output logic [BYTE_W-1:0] data_o
);
  logic [CNT_W-1:0]  word;
  logic [BYTE_W-1:0] bytes [N_BYTES];

  assign word = axis_i ? lat_y_i : lat_x_i;

  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    assign bytes[b] = word[b*BYTE_W +: BYTE_W];
  end

  assign data_o = en_i ? bytes[byte_idx(sel_i)] : '0;
endmodule

// File: rtl/pos_byte_readout.sv
module pos_byte_readout
  import pos_rd_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = N_BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_x_ni,
  input  logic              rst_y_ni,
  input  logic [CNT_W-1:0]  cnt_x_i,
  input  logic [CNT_W-1:0]  cnt_y_i,
  input  logic              oe_ni,
  input  logic [1:0]        byte_sel_i,
  input  logic              axis_sel_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_en_o
);
  localparam int unsigned N_AX = 2;

  logic             rst_n [N_AX];
  logic [CNT_W-1:0] cnt   [N_AX];
  logic [CNT_W-1:0] lat   [N_AX];
  logic             inh   [N_AX];

  assign rst_n[0] = rst_x_ni;
  assign rst_n[1] = rst_y_ni;
  assign cnt[0]   = cnt_x_i;
  assign cnt[1]   = cnt_y_i;

  for (genvar a = 0; a < N_AX; a++) begin : g_axis
    logic rd;
    assign rd = !oe_ni && (axis_sel_i == 1'(a));

    pos_inhibit u_inh (
      .clk_i (clk_i),
      .rst_ni(rst_n[a]),
      .rd_i  (rd),
      .lsb_i (byte_sel_i == SEL_LSB),
      .oe_ni (oe_ni),
      .inh_o (inh[a])
    );

    pos_latch #(.CNT_W(CNT_W)) u_lat (
      .clk_i (clk_i),
      .rst_ni(rst_n[a]),
      .inh_i (inh[a]),
      .cnt_i (cnt[a]),
      .lat_o (lat[a])
    );

    // a read of one axis leaves the other axis tracking
    p_other_axis_r8: assert property (@(negedge clk_i) disable iff (!rst_n[a])
      (!inh[a] && !oe_ni && (axis_sel_i != 1'(a))) |=> !inh[a]);
  end

  pos_byte_mux #(.BYTE_W(BYTE_W)) u_mux (
    .lat_x_i(lat[0]),
    .lat_y_i(lat[1]),
    .axis_i (axis_sel_i),
    .sel_i  (byte_sel_i),
    .en_i   (!oe_ni),
    .data_o (data_o)
  );

  assign data_en_o = !oe_ni;

  always_comb begin
    if (oe_ni) p_idle_bus_r7: assert (data_o == '0);
  end
endmodule

// File: tb/pos_byte_readout_tb.sv
module pos_byte_readout_tb;
  logic        clk = 1'b0;
  logic        rst_x_n = 1'b0, rst_y_n = 1'b0;
  logic [31:0] cnt_x = '0, cnt_y = '0;
  logic        oe_n = 1'b1;
  logic [1:0]  bsel = 2'b00;
  logic        ax = 1'b0;
  logic [7:0]  data;
  logic        data_en;

  int unsigned errors = 0, checks = 0;
  bit          done = 1'b0;

  logic [31:0] m_lat [2];
  bit          m_inh [2];
  bit          m_lsb [2];

  always #4 clk = ~clk;

  pos_byte_readout u_dut (
    .clk_i(clk), .rst_x_ni(rst_x_n), .rst_y_ni(rst_y_n),
    .cnt_x_i(cnt_x), .cnt_y_i(cnt_y), .oe_ni(oe_n),
    .byte_sel_i(bsel), .axis_sel_i(ax),
    .data_o(data), .data_en_o(data_en)
  );

  function automatic logic [7:0] pick(input logic [31:0] w, input logic [1:0] s);
    case (s)
      2'b01:   return w[31:24];
      2'b11:   return w[23:16];
      2'b00:   return w[15:8];
      default: return w[7:0];
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive after rising edge, check, then advance model through both edges
  task automatic step(input logic [31:0] cx, input logic [31:0] cy, input bit o,
                      input logic [1:0] s, input bit a, input bit rx, input bit ry,
                      input string tag);
    bit rs [2];
    @(posedge clk);
    #1;
    cnt_x = cx; cnt_y = cy; oe_n = o; bsel = s; ax = a;
    rst_x_n = rx; rst_y_n = ry;
    rs[0] = rx; rs[1] = ry;
    for (int i = 0; i < 2; i++)
      if (!rs[i]) begin m_lat[i] = '0; m_inh[i] = 1'b0; m_lsb[i] = 1'b0; end
    #2;
    chk({tag, " R7 en"}, {31'd0, data_en}, {31'd0, !o});
    chk({tag, " data"}, {24'd0, data}, o ? 32'd0 : {24'd0, pick(m_lat[a], s)});
    for (int i = 0; i < 2; i++) begin
      if (!rs[i]) continue;
      if (!o && a == 1'(i)) begin
        m_inh[i] = 1'b1;
        if (s == 2'b10) m_lsb[i] = 1'b1;
      end else if (o && m_inh[i] && m_lsb[i]) begin
        m_inh[i] = 1'b0; m_lsb[i] = 1'b0;
      end
    end
    for (int i = 0; i < 2; i++)
      if (rs[i] && !m_inh[i]) m_lat[i] = (i == 0) ? cx : cy;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < 2; i++) begin m_lat[i] = '0; m_inh[i] = 0; m_lsb[i] = 0; end
    // R1 both axes in reset
    step(32'hAABBCCDD, 32'h11223344, 0, 2'b01, 0, 0, 0, "R1 reset x");
    step(32'hAABBCCDD, 32'h11223344, 0, 2'b10, 1, 0, 0, "R1 reset y");
    // R2 tracking with enable high
    step(32'h12345678, 32'h9ABCDEF0, 1, 2'b00, 0, 1, 1, "R2 idle");
    step(32'h0F1E2D3C, 32'h4B5A6978, 1, 2'b00, 0, 1, 1, "R2 idle");
    // R3 R5 freeze and read all four bytes of X while counter moves
    step(32'h01010101, 32'h02020202, 0, 2'b01, 0, 1, 1, "R3 R5 msb");
    step(32'h03030303, 32'h04040404, 0, 2'b11, 0, 1, 1, "R3 R5 byte2");
    step(32'h05050505, 32'h06060606, 0, 2'b00, 0, 1, 1, "R3 R5 byte1");
    // R4 enable high without LSB keeps freeze
    step(32'h07070707, 32'h08080808, 1, 2'b00, 0, 1, 1, "R4 pause");
    step(32'h09090909, 32'h0A0A0A0A, 0, 2'b01, 0, 1, 1, "R4 still frozen");
    // R8 Y read while X frozen
    step(32'h0B0B0B0B, 32'h0C0C0C0C, 0, 2'b11, 1, 1, 1, "R6 R8 y tracks");
    step(32'h0D0D0D0D, 32'h0E0E0E0E, 0, 2'b10, 1, 1, 1, "R6 R8 y lsb");
    step(32'h0F0F0F0F, 32'h10101010, 0, 2'b10, 0, 1, 1, "R5 x lsb");
    step(32'h11111111, 32'h12121212, 1, 2'b10, 0, 1, 1, "R4 release");
    step(32'h13131313, 32'h14141414, 0, 2'b01, 0, 1, 1, "R2 fresh x");
    // R9 8-bit read
    step(32'h15151515, 32'h16161616, 1, 2'b10, 0, 1, 1, "R9 idle");
    step(32'h17171717, 32'h18181818, 0, 2'b10, 1, 1, 1, "R9 lsb only");
    step(32'h19191919, 32'h1A1A1A1A, 1, 2'b10, 1, 1, 1, "R9 release");
    step(32'h1B1B1B1B, 32'h1C1C1C1C, 0, 2'b01, 1, 1, 1, "R9 fresh y");
    // R1 reset of Y only, X unaffected
    step(32'h1D1D1D1D, 32'h1E1E1E1E, 1, 2'b10, 1, 1, 1, "R1 pre");
    step(32'h1F1F1F1F, 32'h20202020, 0, 2'b11, 1, 1, 0, "R1 y reset");
    step(32'h21212121, 32'h22222222, 0, 2'b11, 0, 1, 1, "R1 x kept");
    step(32'h23232323, 32'h24242424, 1, 2'b10, 0, 1, 1, "R1 idle");
    // random mix
    for (int n = 0; n < 600; n++) begin
      bit o, a, rx, ry;
      o  = ($urandom % 3) == 0;
      a  = $urandom % 2;
      rx = ($urandom % 50) != 0;
      ry = ($urandom % 50) != 0;
      step($urandom, $urandom, o, 2'($urandom), a, rx, ry, "R2 R3 R4 R5 R6 rand");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule